// File: doc/BRIEF.md
# I2C Combined Transaction Sequencer

This block drives a byte-level I2C controller engine through one complete transaction: an optional write phase followed by an optional read phase, addressed to a 7-bit target. For every byte it writes a four-bit command word to the engine, together with the address byte (whose least significant bit selects the direction) and, for writes, the outgoing data byte. It then waits for the engine to report that the byte operation has completed. Received bytes are handed out one at a time as the engine reports them.

The host gives a request with the address, the write length, the read length and two flags. One flag asks for a start condition on the first byte. The other asks for a stop condition on the final byte of the whole transaction. The sequencer places a repeated start by itself when the transfer turns from writing to reading. If the start flag is set and the bus does not look idle, it first pulses a reset to the port and waits a recovery time before it issues any command. The transaction ends with a one-cycle done pulse and an error code that holds its value until the next request. An engine fault or an expired transaction timer forces a stop-only command, followed by the same recovery wait.

Top module: `i2c_txn_seq`

## Requirements
- R1: After reset, busy, done, cmd_valid, wr_pop, rd_valid and port_rst are low and err_code is 0.
- R2: Command bits are RUN=bit0, START=bit1, STOP=bit2, ACK=bit3. With start and stop set and no reads, a write of N>1 bytes issues 0x3, then 0x1 for each middle byte, then 0x5. A single-byte write issues 0x7.
- R3: With stop set, a read of N>1 bytes issues RUN|ACK (0x9) on every byte except the last, which gets 0x5. The first read byte also carries START. A single-byte read with start issues 0x7. ACK never appears on a write command.
- R4: cmd_addr is {address, dir}, with dir=0 on write commands and 1 on read commands. When writes are followed by reads, the first read command carries START whatever the start flag is.
- R5: STOP is set on the last write only if the stop flag is set and the read length is zero. It is set on the last read only if the stop flag is set. Without stop, the last read byte is 0x9.
- R6: Each write command comes with one wr_pop pulse in the same cycle, and cmd_data equals the wr_byte value presented for it.
- R7: Each read completion produces one rd_valid pulse, with rd_data equal to the eng_rdata value of that completion, in order.
- R8: A request with both lengths zero gives done on the next cycle with err_code 0 and issues no command.
- R9: If start is requested while a line is low or the engine flags clock timeout or lost arbitration, port_rst pulses once and the first command follows at least IDLE_CYC cycles later. With start not requested, the bus check is skipped.
- R10: A completion that flags timeout, lost arbitration or error, unless the next command is a repeated start, ends issuing. The block sends a stop-only command (0x4), waits at least IDLE_CYC cycles, then signals done with err_code 1.
- R11: If the transaction is still running after TIMEOUT_CYC cycles of issuing and waiting, the block sends 0x4, waits the recovery time and signals done with err_code 2.
- R12: done is a single-cycle pulse with busy low. err_code keeps its value until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_addr | input | 7 | Target address |
| req_wr_len | input | LEN_W | Number of bytes to write |
| req_rd_len | input | LEN_W | Number of bytes to read |
| req_start | input | 1 | Begin with a start condition |
| req_stop | input | 1 | End with a stop condition |
| wr_byte | input | 8 | Next outgoing byte |
| wr_pop | output | 1 | Outgoing byte consumed |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | rd_data holds a new byte |
| cmd_valid | output | 1 | Command word issued to the engine |
| cmd_code | output | 4 | Command bits RUN/START/STOP/ACK |
| cmd_addr | output | 8 | Address byte with direction bit |
| cmd_data | output | 8 | Data byte for a write command |
| eng_done | input | 1 | Engine finished the byte operation |
| eng_rdata | input | 8 | Byte received by the engine |
| eng_clkto | input | 1 | Engine flags clock timeout |
| eng_arblost | input | 1 | Engine flags lost arbitration |
| eng_err | input | 1 | Engine flags missing acknowledge or other error |
| scl_line | input | 1 | Sampled clock line level |
| sda_line | input | 1 | Sampled data line level |
| port_rst | output | 1 | Reset pulse to the port |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Transaction finished |
| err_code | output | 2 | 0 none, 1 bus fault, 2 timeout |

## Verification
The bench builds the sequencer with IDLE_CYC=16, TIMEOUT_CYC=400, LEN_W=4 and two synchronizer stages. With these values, both the port recovery wait and the timer-driven abort complete within a few hundred cycles. The stalled-engine timeout path and the gap after a forced stop can therefore be measured exactly. Transactions of up to five bytes in each direction fit well inside the timer, so normal runs never touch it.

// File: rtl/i2cseq_pkg.sv
`timescale 1ns/1ps
package i2cseq_pkg;
  localparam int CB_RUN   = 0;
  localparam int CB_START = 1;
  localparam int CB_STOP  = 2;
  localparam int CB_ACK   = 3;
  localparam logic [3:0] CMD_STOP_ONLY = 4'b0100;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_BUS     = 2'd1,
    ERR_TIMEOUT = 2'd2
  } err_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECOVER,
    ST_ISSUE,
    ST_WAIT,
    ST_ABORT,
    ST_DRAIN
  } state_e;
endpackage

// File: rtl/i2cseq_cmd_gen.sv
`timescale 1ns/1ps
module i2cseq_cmd_gen
  import i2cseq_pkg::*;
(
  input  logic       is_read,
  input  logic       with_start,
  input  logic       last_byte,
  input  logic       stop_req,
  input  logic       more_reads,
  output logic [3:0] code
);
  always_comb begin
    code = '0;
    code[CB_RUN]   = 1'b1;
    code[CB_START] = with_start;
    if (is_read) begin
      // final read byte is NACKed by stopping; all others are ACKed
      if (last_byte && stop_req) code[CB_STOP] = 1'b1;
      else                       code[CB_ACK]  = 1'b1;
    end else begin
      code[CB_STOP] = last_byte && stop_req && !more_reads;
    end
  end
endmodule

// File: rtl/i2cseq_wait_timer.sv
`timescale 1ns/1ps
module i2cseq_wait_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)            cnt <= '0;
    else if (en && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) cnt <= LIM); // R11
endmodule

// File: rtl/i2cseq_bus_health.sv
`timescale 1ns/1ps
module i2cseq_bus_health #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_line,
  input  logic sda_line,
  input  logic clkto,
  input  logic arblost,
  output logic healthy
);
  logic [STAGES-1:0] scl_s;
  logic [STAGES-1:0] sda_s;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_s[g] <= 1'b1;
          sda_s[g] <= 1'b1;
        end else begin
          scl_s[g] <= scl_line;
          sda_s[g] <= sda_line;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_s[g] <= 1'b1;
          sda_s[g] <= 1'b1;
        end else begin
          scl_s[g] <= scl_s[g-1];
          sda_s[g] <= sda_s[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) healthy <= 1'b1;
    else     healthy <= scl_s[STAGES-1] && sda_s[STAGES-1] && !clkto && !arblost;
  end
endmodule

// File: rtl/i2c_txn_seq.sv
`timescale 1ns/1ps
module i2c_txn_seq
  import i2cseq_pkg::*;
#(
  parameter int LEN_W       = 4,
  parameter int IDLE_CYC    = 50000,
  parameter int TIMEOUT_CYC = 2500000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [6:0]       req_addr,
  input  logic [LEN_W-1:0] req_wr_len,
  input  logic [LEN_W-1:0] req_rd_len,
  input  logic             req_start,
  input  logic             req_stop,
  input  logic [7:0]       wr_byte,
  output logic             wr_pop,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             cmd_valid,
  output logic [3:0]       cmd_code,
  output logic [7:0]       cmd_addr,
  output logic [7:0]       cmd_data,
  input  logic             eng_done,
  input  logic [7:0]       eng_rdata,
  input  logic             eng_clkto,
  input  logic             eng_arblost,
  input  logic             eng_err,
  input  logic             scl_line,
  input  logic             sda_line,
  output logic             port_rst,
  output logic             busy,
  output logic             done,
  output logic [1:0]       err_code
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  state_e           state;
  logic [6:0]       addr_q;
  logic [LEN_W-1:0] wr_left;
  logic [LEN_W-1:0] rd_left;
  logic             need_start;
  logic             stop_q;
  logic             rd_phase;

  logic             bus_ok;
  logic             idle_exp;
  logic             tx_exp;
  logic [3:0]       next_code;
  logic             last_now;
  logic             fault_seen;

  i2cseq_bus_health #(.STAGES(SYNC_STAGES)) u_health (
    .clk      (clk),
    .rst      (rst),
    .scl_line (scl_line),
    .sda_line (sda_line),
    .clkto    (eng_clkto),
    .arblost  (eng_arblost),
    .healthy  (bus_ok)
  );

  i2cseq_wait_timer #(.LIMIT(IDLE_CYC)) u_idle_tmr (
    .clk     (clk),
    .rst     (rst),
    .clr     (!(state == ST_RECOVER || state == ST_DRAIN)),
    .en      (1'b1),
    .expired (idle_exp)
  );

  i2cseq_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_txn_tmr (
    .clk     (clk),
    .rst     (rst),
    .clr     (state == ST_IDLE),
    .en      (state == ST_ISSUE || state == ST_WAIT),
    .expired (tx_exp)
  );

  assign last_now   = rd_phase ? (rd_left == ONE) : (wr_left == ONE);
  assign fault_seen = eng_clkto || eng_arblost || eng_err;

  i2cseq_cmd_gen u_cmd (
    .is_read    (rd_phase),
    .with_start (need_start),
    .last_byte  (last_now),
    .stop_req   (stop_q),
    .more_reads (rd_left != '0),
    .code       (next_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      addr_q     <= '0;
      wr_left    <= '0;
      rd_left    <= '0;
      need_start <= 1'b0;
      stop_q     <= 1'b0;
      rd_phase   <= 1'b0;
      wr_pop     <= 1'b0;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
      cmd_valid  <= 1'b0;
      cmd_code   <= '0;
      cmd_addr   <= '0;
      cmd_data   <= '0;
      port_rst   <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      err_code   <= ERR_NONE;
    end else begin
      cmd_valid <= 1'b0;
      wr_pop    <= 1'b0;
      rd_valid  <= 1'b0;
      port_rst  <= 1'b0;
      done      <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q     <= req_addr;
            wr_left    <= req_wr_len;
            rd_left    <= req_rd_len;
            need_start <= req_start;
            stop_q     <= req_stop;
            rd_phase   <= (req_wr_len == '0);
            err_code   <= ERR_NONE;
            if (req_wr_len == '0 && req_rd_len == '0) begin
              done <= 1'b1;
            end else if (req_start && !bus_ok) begin
              busy     <= 1'b1;
              port_rst <= 1'b1;
              state    <= ST_RECOVER;
            end else begin
              busy  <= 1'b1;
              state <= ST_ISSUE;
            end
          end
        end
        ST_RECOVER: begin
          if (idle_exp) state <= ST_ISSUE;
        end
        ST_ISSUE: begin
          cmd_valid  <= 1'b1;
          cmd_code   <= next_code;
          cmd_addr   <= {addr_q, rd_phase};
          need_start <= 1'b0;
          if (rd_phase) begin
            rd_left <= rd_left - ONE;
          end else begin
            cmd_data <= wr_byte;
            wr_pop   <= 1'b1;
            wr_left  <= wr_left - ONE;
            // direction turn: the first read gets a repeated start
            if (wr_left == ONE && rd_left != '0) need_start <= 1'b1;
          end
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (tx_exp) begin
            err_code <= ERR_TIMEOUT;
            state    <= ST_ABORT;
          end else if (eng_done) begin
            if (!need_start && fault_seen) begin
              err_code <= ERR_BUS;
              state    <= ST_ABORT;
            end else begin
              if (rd_phase) begin
                rd_data  <= eng_rdata;
                rd_valid <= 1'b1;
              end
              if (!rd_phase && wr_left != '0) begin
                state <= ST_ISSUE;
              end else if (!rd_phase && rd_left != '0) begin
                rd_phase <= 1'b1;
                state    <= ST_ISSUE;
              end else if (rd_phase && rd_left != '0) begin
                state <= ST_ISSUE;
              end else begin
                done  <= 1'b1;
                busy  <= 1'b0;
                state <= ST_IDLE;
              end
            end
          end
        end
        ST_ABORT: begin
          cmd_valid <= 1'b1;
          cmd_code  <= CMD_STOP_ONLY;
          state     <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (idle_exp) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_WRPOP_WITH_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_pop |-> (cmd_valid && !cmd_addr[0])); // R6
  AST_ACK_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code[CB_ACK]) |-> cmd_addr[0]); // R3
  AST_STOP_ONLY_FORM: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_code[CB_RUN]) |-> (cmd_code == CMD_STOP_ONLY)); // R10
  AST_RD_QUIET_CMD: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !cmd_valid); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !cmd_valid)); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R12
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!busy && !req_valid) |=> $stable(err_code)); // R12
  AST_RST_NO_CMD: assert property (@(posedge clk) disable iff (rst)
    port_rst |=> !cmd_valid); // R9
endmodule

// File: tb/sim_i2c_txn_seq.sv
`timescale 1ns/1ps
module sim_i2c_txn_seq;
  localparam int LEN_W = 4;
  localparam int IDLE  = 16;
  localparam int TMO   = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic             req_valid, req_start, req_stop;
  logic [6:0]       req_addr;
  logic [LEN_W-1:0] req_wr_len, req_rd_len;
  logic [7:0]       wr_byte;
  logic             wr_pop, rd_valid, cmd_valid, port_rst, busy, done;
  logic [7:0]       rd_data, cmd_addr, cmd_data;
  logic [3:0]       cmd_code;
  logic             eng_done, eng_clkto, eng_arblost, eng_err;
  logic [7:0]       eng_rdata;
  logic             scl_line, sda_line;
  logic [1:0]       err_code;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0, fails = 0;
  int pend, n_cmp, err_at, hang;
  int n_cmd, n_pop, wr_ptr, n_rd, n_prst, prst_cyc, n_done, done_cyc;
  logic [3:0] lg_code [0:63];
  logic [7:0] lg_addr [0:63];
  logic [7:0] lg_data [0:63];
  int         lg_cyc  [0:63];
  logic [7:0] rd_log  [0:31];

  assign wr_byte = 8'h30 + 8'(wr_ptr);

  // {wr_len, rd_len, start, stop}
  localparam logic [9:0] VEC [0:8] = '{
    {4'd1, 4'd0, 1'b1, 1'b1},
    {4'd3, 4'd0, 1'b1, 1'b1},
    {4'd0, 4'd1, 1'b1, 1'b1},
    {4'd0, 4'd4, 1'b1, 1'b1},
    {4'd2, 4'd3, 1'b1, 1'b1},
    {4'd2, 4'd2, 1'b1, 1'b0},
    {4'd3, 4'd0, 1'b1, 1'b0},
    {4'd1, 4'd1, 1'b0, 1'b1},
    {4'd5, 4'd5, 1'b1, 1'b1}
  };

  i2c_txn_seq #(.LEN_W(LEN_W), .IDLE_CYC(IDLE), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_wr_len(req_wr_len), .req_rd_len(req_rd_len), .req_start(req_start),
    .req_stop(req_stop), .wr_byte(wr_byte), .wr_pop(wr_pop), .rd_data(rd_data),
    .rd_valid(rd_valid), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .eng_done(eng_done),
    .eng_rdata(eng_rdata), .eng_clkto(eng_clkto), .eng_arblost(eng_arblost),
    .eng_err(eng_err), .scl_line(scl_line), .sda_line(sda_line),
    .port_rst(port_rst), .busy(busy), .done(done), .err_code(err_code)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_code(input int i, input int wr, input int rd,
                                          input bit st, input bit sp);
    logic [3:0] c;
    c = 4'b0001;
    if (i < wr) begin
      if (i == 0 && st) c[1] = 1'b1;
      if (i == wr - 1 && sp && rd == 0) c[2] = 1'b1;
    end else begin
      if (i == wr && (wr > 0 || st)) c[1] = 1'b1;
      if (i - wr == rd - 1 && sp) c[2] = 1'b1;
      else c[3] = 1'b1;
    end
    return c;
  endfunction

  task automatic engine();
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      eng_err  = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          eng_done  = 1'b1;
          eng_rdata = 8'hA0 + 8'(n_cmp);
          if (n_cmp == err_at) eng_err = 1'b1;
          n_cmp++;
        end
      end
      if (cmd_valid && n_cmd < 64) begin
        lg_code[n_cmd] = cmd_code;
        lg_addr[n_cmd] = cmd_addr;
        lg_data[n_cmd] = cmd_data;
        lg_cyc[n_cmd]  = cyc;
        n_cmd++;
        if (cmd_code[0] && hang == 0) pend = 3;
      end
      if (wr_pop) begin n_pop++; wr_ptr++; end
      if (rd_valid && n_rd < 32) begin rd_log[n_rd] = rd_data; n_rd++; end
      if (port_rst) begin n_prst++; prst_cyc = cyc; end
      if (done) begin n_done++; done_cyc = cyc; end
    end
  endtask

  task automatic watchdog();
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R12 watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic run_txn(input int wr, input int rd, input bit st, input bit sp);
    n_cmd = 0; n_pop = 0; wr_ptr = 0; n_rd = 0; n_cmp = 0;
    n_done = 0; n_prst = 0; pend = 0;
    @(negedge clk);
    req_valid  = 1'b1;
    req_addr   = 7'h5A;
    req_wr_len = LEN_W'(wr);
    req_rd_len = LEN_W'(rd);
    req_start  = st;
    req_stop   = sp;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 2000 && n_done == 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_normal(input int wr, input int rd, input bit st, input bit sp);
    check(n_cmd == wr + rd, "R2 command count", n_cmd, wr + rd);
    for (int i = 0; i < wr + rd && i < 64; i++) begin
      if (i < wr) check(lg_code[i] == exp_code(i, wr, rd, st, sp), "R2 write code", lg_code[i], exp_code(i, wr, rd, st, sp));
      else if (i - wr == rd - 1) check(lg_code[i] == exp_code(i, wr, rd, st, sp), "R5 last read code", lg_code[i], exp_code(i, wr, rd, st, sp));
      else check(lg_code[i] == exp_code(i, wr, rd, st, sp), "R3 read code", lg_code[i], exp_code(i, wr, rd, st, sp));
      check(lg_addr[i] == {7'h5A, (i >= wr)}, "R4 address byte", lg_addr[i], {7'h5A, (i >= wr)});
      if (i < wr) check(lg_data[i] == 8'h30 + 8'(i), "R6 write data", lg_data[i], 8'h30 + i);
    end
    check(n_pop == wr, "R6 pop count", n_pop, wr);
    check(n_rd == rd, "R7 read count", n_rd, rd);
    for (int j = 0; j < rd && j < 32; j++)
      check(rd_log[j] == 8'hA0 + 8'(wr + j), "R7 read byte", rd_log[j], 8'hA0 + wr + j);
    check(n_done == 1 && !busy, "R12 single done", n_done, 1);
    check(err_code == 2'd0, "R12 clean status", err_code, 0);
  endtask

  initial begin
    req_valid = 0; req_start = 0; req_stop = 0; req_addr = '0;
    req_wr_len = '0; req_rd_len = '0;
    eng_done = 0; eng_clkto = 0; eng_arblost = 0; eng_err = 0; eng_rdata = '0;
    scl_line = 1; sda_line = 1;
    pend = 0; n_cmp = 0; err_at = -1; hang = 0;
    n_cmd = 0; n_pop = 0; wr_ptr = 0; n_rd = 0; n_prst = 0; prst_cyc = 0;
    n_done = 0; done_cyc = 0;
    fork
      engine();
      watchdog();
    join_none
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !cmd_valid && !wr_pop && !rd_valid && !port_rst,
          "R1 outputs idle", {busy, done, cmd_valid, wr_pop, rd_valid, port_rst}, 0);
    check(err_code == 2'd0, "R1 error code", err_code, 0);

    for (int v = 0; v < 9; v++) begin
      run_txn(VEC[v][9:6], VEC[v][5:2], VEC[v][1], VEC[v][0]);
      check_normal(VEC[v][9:6], VEC[v][5:2], VEC[v][1], VEC[v][0]);
    end

    // R8 empty request
    run_txn(0, 0, 1, 1);
    check(n_cmd == 0, "R8 no command", n_cmd, 0);
    check(n_done == 1 && err_code == 2'd0, "R8 done clean", n_done, 1);

    // R9 unhealthy bus with start
    sda_line = 1'b0;
    repeat (6) @(negedge clk);
    run_txn(2, 1, 1, 1);
    check(n_prst == 1, "R9 port reset pulse", n_prst, 1);
    check(lg_cyc[0] - prst_cyc >= IDLE, "R9 recovery gap", lg_cyc[0] - prst_cyc, IDLE);
    check(lg_code[0] == 4'h3 && lg_code[2] == 4'h7, "R9 codes after recovery", lg_code[2], 7);
    // R9 no start: check skipped
    run_txn(1, 0, 0, 1);
    check(n_prst == 0, "R9 no reset without start", n_prst, 0);
    check(n_cmd == 1 && lg_code[0] == 4'h5, "R9 plain write", lg_code[0], 5);
    sda_line = 1'b1;
    repeat (6) @(negedge clk);

    // R10 fault on the second completion
    err_at = 1;
    run_txn(4, 0, 1, 1);
    check(n_cmd == 3, "R10 issuing stops", n_cmd, 3);
    check(lg_code[2] == 4'h4, "R10 stop-only command", lg_code[2], 4);
    check(err_code == 2'd1, "R10 bus error code", err_code, 1);
    check(done_cyc - lg_cyc[2] >= IDLE, "R10 idle after stop", done_cyc - lg_cyc[2], IDLE);
    repeat (8) @(negedge clk);
    check(err_code == 2'd1 && !done, "R12 error sticky", err_code, 1);

    // R10 fault before a repeated start is not checked
    err_at = 0;
    run_txn(1, 2, 1, 1);
    check(n_cmd == 3 && lg_code[1] == 4'hB && lg_code[2] == 4'h5, "R10 turn exempt", lg_code[1], 11);
    check(err_code == 2'd0, "R12 error cleared by request", err_code, 0);
    err_at = -1;

    // R11 engine never completes
    hang = 1;
    run_txn(2, 0, 1, 1);
    check(n_cmd == 2 && lg_code[0] == 4'h3, "R11 first command only", n_cmd, 2);
    check(lg_code[1] == 4'h4, "R11 stop-only command", lg_code[1], 4);
    check(err_code == 2'd2, "R11 timeout code", err_code, 2);
    check(lg_cyc[1] - lg_cyc[0] >= TMO, "R11 timer length", lg_cyc[1] - lg_cyc[0], TMO);
    hang = 0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule